// File: doc/BRIEF.md
# Line Transceiver Power-Down and Loopback Mode Control

This block sets the operating mode of one channel of a line transceiver. It merges two kinds of input. The first is the configuration register bits: transmit power-down, receive power-down, local loopback and remote loopback. The second is the hardware control inputs: a pin that forces transmit power-down, and a three-level loopback pin. Pad logic upstream has already resolved the loopback pin into separate low, float and high indications. A mode input chooses whether the register bits or the loopback pin set the loopback path.

The outputs drive the rest of the channel: power-down enables for the transmitter and the receiver, an output enable for the line driver, and two path selects.
- The remote select routes the recovered receive clock and data into the transmit path.
- The local select routes the transmit clock and data into the receive path.

Global power-down is the state in which both directions are powered down. It has no control bit of its own. Every control output comes from a register, so it changes one clock after its inputs. Reset returns the channel to normal operation with both directions powered up.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge the outputs become `tx_pd`=0, `rx_pd`=0, `line_oe`=1, `rlb_sel`=0 and `llb_sel`=0.
- R2: In software mode (`hw_mode`=0), `tx_pd` and `rx_pd` follow `cfg_tx_pd` and `cfg_rx_pd` independently, one clock later.
- R3: In software mode, setting both power-down bits powers down both directions together (global power-down). No other input is needed for this state.
- R4: When `tx_off_pin`=1, `tx_pd`=1 one clock later, in both hardware and software modes.
- R5: `line_oe` is 0 exactly while `tx_pd` is 1, so the line outputs are high impedance during transmit power-down.
- R6: In software mode, `cfg_lb_local`=1 sets `llb_sel`, and `cfg_lb_remote`=1 alone sets `rlb_sel`, one clock later.
- R7: In software mode with both loopback bits set, only `llb_sel` is 1.
- R8: In hardware mode (`hw_mode`=1), the loopback pin sets the path one clock later: low gives normal operation, float gives remote loopback and high gives local loopback. The register loopback bits have no effect.
- R9: In hardware mode, `cfg_tx_pd` and `cfg_rx_pd` have no effect: `rx_pd`=0, and `tx_pd` equals `tx_off_pin`.
- R10: At most one of `rlb_sel` and `llb_sel` is 1 at any time.
- R11: If the loopback pin indications are not one-hot in hardware mode, high takes priority over float. With neither high nor float set, the result is normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_mode | input | 1 | 1 selects hardware pin control, 0 selects register control |
| tx_off_pin | input | 1 | Transmit power-down pin, effective in both modes |
| cfg_tx_pd | input | 1 | Register bit: transmit power-down |
| cfg_rx_pd | input | 1 | Register bit: receive power-down |
| cfg_lb_local | input | 1 | Register bit: local loopback |
| cfg_lb_remote | input | 1 | Register bit: remote loopback |
| lb3_lo | input | 1 | Loopback pin resolved low |
| lb3_float | input | 1 | Loopback pin resolved floating |
| lb3_hi | input | 1 | Loopback pin resolved high |
| tx_pd | output | 1 | Transmitter power-down enable |
| rx_pd | output | 1 | Receiver power-down enable |
| line_oe | output | 1 | Line driver output enable (0 = high impedance) |
| rlb_sel | output | 1 | Route recovered receive clock/data into transmit path |
| llb_sel | output | 1 | Route transmit clock/data into receive path |

## Verification
A wrong decode or a stale register shows at the ports on the very next clock. Examples are a swapped loopback encoding, a register bit leaking through in hardware mode, and a lost pin override. Every input combination is applied and held for one cycle, so any fault that depends on the combination of inputs appears within one clock of the vector that exposes it. If `line_oe` and `tx_pd` fall out of step, or both path selects are active at once, the line would be contended or the data paths corrupted. Both conditions are checked on every cycle.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'b00,
        LB_REMOTE = 2'b01,
        LB_LOCAL  = 2'b10
    } lb_mode_e;

    typedef struct packed {
        logic tx_pd;
        logic rx_pd;
    } pd_req_t;

    typedef struct packed {
        logic     tx_pd;
        logic     rx_pd;
        logic     line_oe;
        lb_mode_e lb;
    } mode_ctrl_t;

    localparam mode_ctrl_t CTRL_RESET = '{tx_pd: 1'b0, rx_pd: 1'b0,
                                          line_oe: 1'b1, lb: LB_NORMAL};

    // Register loopback bits: local has priority over remote.
    function automatic lb_mode_e sw_lb(input logic loc, input logic rem);
        if (loc)      return LB_LOCAL;
        else if (rem) return LB_REMOTE;
        else          return LB_NORMAL;
    endfunction

    // Three-level pin: one-hot cases decode directly; otherwise high > float > normal.
    function automatic lb_mode_e pin_lb(input logic lo, input logic flt, input logic hi);
        case ({hi, flt, lo})
            3'b100:  return LB_LOCAL;
            3'b010:  return LB_REMOTE;
            3'b001:  return LB_NORMAL;
            default: begin
                if (hi)       return LB_LOCAL;
                else if (flt) return LB_REMOTE;
                else          return LB_NORMAL;
            end
        endcase
    endfunction

endpackage

// File: rtl/xm_lb_select.sv
module xm_lb_select
    import xcvr_mode_pkg::*;
(
    input  logic     hw_mode,
    input  logic     cfg_local,
    input  logic     cfg_remote,
    input  logic     pin_lo,
    input  logic     pin_float,
    input  logic     pin_hi,
    output lb_mode_e lb_next
);
    always_comb begin
        if (hw_mode) lb_next = pin_lb(pin_lo, pin_float, pin_hi);
        else         lb_next = sw_lb(cfg_local, cfg_remote);
    end
endmodule

// File: rtl/xm_pd_select.sv
module xm_pd_select
    import xcvr_mode_pkg::*;
(
    input  logic    hw_mode,
    input  logic    tx_off_pin,
    input  logic    cfg_tx_pd,
    input  logic    cfg_rx_pd,
    output pd_req_t pd_next
);
    always_comb begin
        pd_next.tx_pd = tx_off_pin | (~hw_mode & cfg_tx_pd);
        pd_next.rx_pd = ~hw_mode & cfg_rx_pd;
    end
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hw_mode,
    input  logic tx_off_pin,
    input  logic cfg_tx_pd,
    input  logic cfg_rx_pd,
    input  logic cfg_lb_local,
    input  logic cfg_lb_remote,
    input  logic lb3_lo,
    input  logic lb3_float,
    input  logic lb3_hi,
    output logic tx_pd,
    output logic rx_pd,
    output logic line_oe,
    output logic rlb_sel,
    output logic llb_sel
);
    lb_mode_e   lb_next;
    pd_req_t    pd_next;
    mode_ctrl_t ctrl_d;
    mode_ctrl_t ctrl_q;

    xm_lb_select u_lb (
        .hw_mode    (hw_mode),
        .cfg_local  (cfg_lb_local),
        .cfg_remote (cfg_lb_remote),
        .pin_lo     (lb3_lo),
        .pin_float  (lb3_float),
        .pin_hi     (lb3_hi),
        .lb_next    (lb_next)
    );

    xm_pd_select u_pd (
        .hw_mode    (hw_mode),
        .tx_off_pin (tx_off_pin),
        .cfg_tx_pd  (cfg_tx_pd),
        .cfg_rx_pd  (cfg_rx_pd),
        .pd_next    (pd_next)
    );

    always_comb begin
        ctrl_d.tx_pd   = pd_next.tx_pd;
        ctrl_d.rx_pd   = pd_next.rx_pd;
        ctrl_d.line_oe = ~pd_next.tx_pd;
        ctrl_d.lb      = lb_next;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RESET;
        else     ctrl_q <= ctrl_d;
    end

    assign tx_pd   = ctrl_q.tx_pd;
    assign rx_pd   = ctrl_q.rx_pd;
    assign line_oe = ctrl_q.line_oe;
    assign rlb_sel = (ctrl_q.lb == LB_REMOTE);
    assign llb_sel = (ctrl_q.lb == LB_LOCAL);
endmodule

// File: rtl/xcvr_mode_ctrl_chk.sv
module xcvr_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic hw_mode,
    input logic tx_off_pin,
    input logic cfg_rx_pd,
    input logic cfg_lb_local,
    input logic lb3_float,
    input logic lb3_hi,
    input logic tx_pd,
    input logic rx_pd,
    input logic line_oe,
    input logic rlb_sel,
    input logic llb_sel
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!tx_pd && !rx_pd && line_oe && !rlb_sel && !llb_sel));

    a_r2_sw_rx_follow: assert property (@(posedge clk) disable iff (rst)
        !hw_mode |=> (rx_pd == $past(cfg_rx_pd)));

    a_r4_pin_forces_tx: assert property (@(posedge clk) disable iff (rst)
        tx_off_pin |=> tx_pd);

    a_r5_oe_tracks_pd: assert property (@(posedge clk) disable iff (rst)
        line_oe != tx_pd);

    a_r7_local_wins: assert property (@(posedge clk) disable iff (rst)
        (!hw_mode && cfg_lb_local) |=> (llb_sel && !rlb_sel));

    a_r8_hw_float_remote: assert property (@(posedge clk) disable iff (rst)
        (hw_mode && lb3_float && !lb3_hi) |=> rlb_sel);

    a_r9_hw_rx_up: assert property (@(posedge clk) disable iff (rst)
        hw_mode |=> !rx_pd);

    a_r10_one_path: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rlb_sel, llb_sel}));
endmodule

bind xcvr_mode_ctrl xcvr_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .hw_mode      (hw_mode),
    .tx_off_pin   (tx_off_pin),
    .cfg_rx_pd    (cfg_rx_pd),
    .cfg_lb_local (cfg_lb_local),
    .lb3_float    (lb3_float),
    .lb3_hi       (lb3_hi),
    .tx_pd        (tx_pd),
    .rx_pd        (rx_pd),
    .line_oe      (line_oe),
    .rlb_sel      (rlb_sel),
    .llb_sel      (llb_sel)
);

// File: tb/xcvr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hw_mode = 0, tx_off_pin = 0, cfg_tx_pd = 0, cfg_rx_pd = 0;
    logic cfg_lb_local = 0, cfg_lb_remote = 0, lb3_lo = 0, lb3_float = 0, lb3_hi = 0;
    logic tx_pd, rx_pd, line_oe, rlb_sel, llb_sel;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xcvr_mode_ctrl u_dut (
        .clk(clk), .rst(rst), .hw_mode(hw_mode), .tx_off_pin(tx_off_pin),
        .cfg_tx_pd(cfg_tx_pd), .cfg_rx_pd(cfg_rx_pd),
        .cfg_lb_local(cfg_lb_local), .cfg_lb_remote(cfg_lb_remote),
        .lb3_lo(lb3_lo), .lb3_float(lb3_float), .lb3_hi(lb3_hi),
        .tx_pd(tx_pd), .rx_pd(rx_pd), .line_oe(line_oe),
        .rlb_sel(rlb_sel), .llb_sel(llb_sel)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "tx_pd", tx_pd, 1'b0);
        check("R1", "rx_pd", rx_pd, 1'b0);
        check("R1", "line_oe", line_oe, 1'b1);
        check("R1", "rlb_sel", rlb_sel, 1'b0);
        check("R1", "llb_sel", llb_sel, 1'b0);
        rst = 1'b0;

        for (int v = 0; v < 512; v++) begin
            logic e_tx, e_rx, e_rl, e_ll;
            {hw_mode, tx_off_pin, cfg_tx_pd, cfg_rx_pd, cfg_lb_local,
             cfg_lb_remote, lb3_lo, lb3_float, lb3_hi} = v[8:0];
            if (hw_mode) begin
                e_tx = tx_off_pin;
                e_rx = 1'b0;
                e_ll = lb3_hi;
                e_rl = !lb3_hi && lb3_float;
            end else begin
                e_tx = tx_off_pin | cfg_tx_pd;
                e_rx = cfg_rx_pd;
                e_ll = cfg_lb_local;
                e_rl = !cfg_lb_local && cfg_lb_remote;
            end
            @(negedge clk);
            if (tx_off_pin)                    check("R4", "tx_pd pin", tx_pd, e_tx);
            else if (hw_mode)                  check("R9", "tx_pd hw", tx_pd, e_tx);
            else if (cfg_tx_pd && cfg_rx_pd)   check("R3", "tx_pd global", tx_pd, e_tx);
            else                               check("R2", "tx_pd sw", tx_pd, e_tx);
            if (hw_mode)                       check("R9", "rx_pd hw", rx_pd, e_rx);
            else if (cfg_tx_pd && cfg_rx_pd)   check("R3", "rx_pd global", rx_pd, e_rx);
            else                               check("R2", "rx_pd sw", rx_pd, e_rx);
            check("R5", "line_oe", line_oe, !e_tx);
            if (hw_mode && ($countones({lb3_lo, lb3_float, lb3_hi}) != 1)) begin
                check("R11", "rlb_sel", rlb_sel, e_rl);
                check("R11", "llb_sel", llb_sel, e_ll);
            end else if (hw_mode) begin
                check("R8", "rlb_sel", rlb_sel, e_rl);
                check("R8", "llb_sel", llb_sel, e_ll);
            end else if (cfg_lb_local && cfg_lb_remote) begin
                check("R7", "rlb_sel", rlb_sel, e_rl);
                check("R7", "llb_sel", llb_sel, e_ll);
            end else begin
                check("R6", "rlb_sel", rlb_sel, e_rl);
                check("R6", "llb_sel", llb_sel, e_ll);
            end
            check("R10", "one path", rlb_sel & llb_sel, 1'b0);
        end

        // R1: reset from a non-default state
        hw_mode = 0; cfg_tx_pd = 1; cfg_rx_pd = 1; cfg_lb_local = 1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1", "tx_pd after reset", tx_pd, 1'b0);
        check("R1", "rx_pd after reset", rx_pd, 1'b0);
        check("R1", "llb_sel after reset", llb_sel, 1'b0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule